// File: doc/BRIEF.md
# Priority-Arbitrated Atomic Reservation Monitor

This block sits beside one core's first-level cache and tracks the state of that core's atomic sequences. A load-linked opens a reservation on one cache line and records the priority of the thread that opened it. A store-conditional later closes the reservation, and it succeeds only when the reservation is still intact. A compare-and-swap runs as a single fetch-and-compare operation. Both load-linked and compare-and-swap send a fetch with intent to modify, asking for exclusive ownership of the line. They then wait for a fill that says whether ownership was granted.

The two atomic forms behave differently when ownership is refused. A load-linked still completes normally, but its reservation is quietly marked lost, and the loss shows only when the store-conditional fails. A compare-and-swap fails at once when ownership is refused, and in that case it does not compare data. Other agents send snoops, each carrying its own priority. When a snoop lands on the reserved line, the party with the higher priority keeps its sequence. The current holder wins a tie. The snoop is answered with grant or deny on the same cycle. A contention hint pulses on that cycle so that software can back off early.

While a reservation is open, a strict-ordering flag is raised for the core's memory pipeline.

Top module: `resv_monitor`

## Requirements
- R1: An accepted load-linked (req_op 0) or compare-and-swap (req_op 2) raises fetch_valid for exactly one cycle, on the cycle after it is accepted. The fetch_addr it carries has the line-offset bits (the low log2(LINE_BYTES) bits) cleared.
- R2: A load-linked always responds with resp_ok=1 and resp_data equal to the fill data, one cycle after the fill, whether or not fill_excl is set.
- R3: After a load-linked whose fill had fill_excl=0, the next store-conditional (req_op 1) to that line responds with resp_ok=0 and does not assert wr_valid.
- R4: A compare-and-swap whose fill has fill_excl=0 responds with resp_ok=0 and no write, even when the fill data equals the comparand.
- R5: A compare-and-swap whose fill has fill_excl=1 succeeds exactly when the fill data equals req_cmp. On success it writes req_data to req_addr. resp_data always returns the fill data.
- R6: A snoop that hits the reserved line with a priority strictly higher than the holder's is granted, and the holder's next store-conditional fails.
- R7: A snoop that hits the reserved line with a priority lower than or equal to the holder's is denied. The reservation survives, and the next store-conditional succeeds and writes.
- R8: A snoop to any byte of the reserved line counts as a hit. A snoop to another line, or with no reservation open, is granted and has no effect on the reservation.
- R9: order_strict is 0 after reset. It rises on the cycle after a load-linked is accepted and stays high until a store-conditional is accepted. It is low on the cycle after that store-conditional.
- R10: A store-conditional with no open reservation, or to a line other than the reserved one, fails without a write. Every store-conditional closes the reservation, so a second store-conditional fails.
- R11: snp_hint is high on a snoop cycle exactly when the snoop hits an open reservation, whichever side wins.
- R12: req_ready is low while a fetch is outstanding. A request presented then is ignored and does not change the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Monitor can accept a request |
| req_op | input | 2 | 0 load-linked, 1 store-conditional, 2 compare-and-swap, 3 ignored |
| req_addr | input | AW | Byte address |
| req_prio | input | PW | Priority of the requesting thread |
| req_cmp | input | DW | Comparand for compare-and-swap |
| req_data | input | DW | Store data for store-conditional, swap value for compare-and-swap |
| resp_valid | output | 1 | Response strobe |
| resp_ok | output | 1 | Operation succeeded |
| resp_data | output | DW | Loaded value (0 for store-conditional) |
| fetch_valid | output | 1 | Fetch-with-intent-to-modify strobe |
| fetch_addr | output | AW | Line-aligned fetch address |
| fill_valid | input | 1 | Fill response strobe |
| fill_excl | input | 1 | Exclusive ownership was granted |
| fill_data | input | DW | Data of the addressed word |
| wr_valid | output | 1 | Commit a store to the cache |
| wr_addr | output | AW | Store address |
| wr_data | output | DW | Store data |
| snp_valid | input | 1 | Snoop from another agent |
| snp_addr | input | AW | Snoop byte address |
| snp_prio | input | PW | Snooping agent's priority |
| snp_grant | output | 1 | Exclusivity granted (1) or denied (0), same cycle |
| snp_hint | output | 1 | Snoop hit an open reservation |
| order_strict | output | 1 | Strict-ordering mode while a reservation is open |

## Verification
A reservation flag that is lost or wrongly kept does not show at once. It shows at the next store-conditional, as a wrong resp_ok or a write that appears or goes missing. The sooner place to see it is the grant and hint of a snoop that lands between the load-linked and the store-conditional. A stored line or priority that is corrupted shows on the same cycle as a wrong grant or deny, because snoops are answered combinationally. The bench therefore sweeps every pair of holder and snooper priority, together with in-line and out-of-line offsets, and observes both the snoop answer and the following store-conditional.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINE_BYTES = 64,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [PW-1:0] req_prio,
  input  logic [DW-1:0] req_cmp,
  input  logic [DW-1:0] req_data,
  output logic          resp_valid,
  output logic          resp_ok,
  output logic [DW-1:0] resp_data,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  input  logic          fill_valid,
  input  logic          fill_excl,
  input  logic [DW-1:0] fill_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic [PW-1:0] snp_prio,
  output logic          snp_grant,
  output logic          snp_hint,
  output logic          order_strict
);
  localparam int OFF = $clog2(LINE_BYTES);
  localparam int LW = AW - OFF;

  typedef enum logic [1:0] {S_IDLE, S_LL, S_CAS} st_t;
  st_t st;

  logic          resv_open, resv_ok;
  logic [LW-1:0] resv_line;
  logic [PW-1:0] resv_prio;
  logic [AW-1:0] cas_addr;
  logic [DW-1:0] cas_cmp, cas_data;

  wire snp_hit   = snp_valid && resv_open && (snp_addr[AW-1:OFF] == resv_line);
  wire snp_steal = snp_hit && (snp_prio > resv_prio);
  assign snp_hint  = snp_hit;
  assign snp_grant = snp_valid && !(snp_hit && !snp_steal);

  assign req_ready    = (st == S_IDLE);
  assign order_strict = resv_open;

  wire acc     = req_valid && req_ready;
  wire acc_ll  = acc && req_op == 2'd0;
  wire acc_sc  = acc && req_op == 2'd1;
  wire acc_cas = acc && req_op == 2'd2;
  wire sc_ok   = resv_open && resv_ok && !snp_steal && (req_addr[AW-1:OFF] == resv_line);
  wire fill_ll  = (st == S_LL)  && fill_valid;
  wire fill_cas = (st == S_CAS) && fill_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      resv_open <= 1'b0;
      resv_ok <= 1'b0;
      resv_line <= '0;
      resv_prio <= '0;
      cas_addr <= '0;
      cas_cmp <= '0;
      cas_data <= '0;
      resp_valid <= 1'b0;
      resp_ok <= 1'b0;
      resp_data <= '0;
      fetch_valid <= 1'b0;
      fetch_addr <= '0;
      wr_valid <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      resp_valid <= 1'b0;
      wr_valid <= 1'b0;
      fetch_valid <= 1'b0;
      if (snp_steal) resv_ok <= 1'b0;
      if (acc_ll || acc_cas) begin
        fetch_valid <= 1'b1;
        fetch_addr <= {req_addr[AW-1:OFF], {OFF{1'b0}}};
      end
      if (acc_ll) begin
        resv_open <= 1'b1;
        resv_ok <= 1'b1;
        resv_line <= req_addr[AW-1:OFF];
        resv_prio <= req_prio;
        st <= S_LL;
      end
      if (acc_cas) begin
        cas_addr <= req_addr;
        cas_cmp <= req_cmp;
        cas_data <= req_data;
        st <= S_CAS;
      end
      if (acc_sc) begin
        resv_open <= 1'b0;
        resv_ok <= 1'b0;
        resp_valid <= 1'b1;
        resp_ok <= sc_ok;
        resp_data <= '0;
        if (sc_ok) begin
          wr_valid <= 1'b1;
          wr_addr <= req_addr;
          wr_data <= req_data;
        end
      end
      if (fill_ll) begin
        resp_valid <= 1'b1;
        resp_ok <= 1'b1;
        resp_data <= fill_data;
        if (!fill_excl) resv_ok <= 1'b0;
        st <= S_IDLE;
      end
      if (fill_cas) begin
        resp_valid <= 1'b1;
        resp_ok <= fill_excl && (fill_data == cas_cmp);
        resp_data <= fill_data;
        if (fill_excl && fill_data == cas_cmp) begin
          wr_valid <= 1'b1;
          wr_addr <= cas_addr;
          wr_data <= cas_data;
        end
        st <= S_IDLE;
      end
    end
  end

  assert_fetch_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $past(acc_ll || acc_cas));
  assert_ll_no_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(st == S_LL)) |-> resp_ok);
  assert_cas_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_cas && !fill_excl) |-> (resp_valid && !resp_ok && !wr_valid));
  assert_deny_only_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_grant) |-> snp_hint);
  assert_strict_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_sc) |-> !order_strict);
  assert_write_needs_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (resp_valid && resp_ok));
  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !req_ready);
endmodule

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [31:0] req_addr = 0, req_cmp = 0, req_data = 0;
  logic [1:0] req_prio = 0;
  logic resp_valid, resp_ok, fetch_valid, wr_valid;
  logic [31:0] resp_data, fetch_addr, wr_addr, wr_data;
  logic fill_valid = 0, fill_excl = 0;
  logic [31:0] fill_data = 0;
  logic snp_valid = 0;
  logic [31:0] snp_addr = 0;
  logic [1:0] snp_prio = 0;
  logic snp_grant, snp_hint, order_strict;

  int compared = 0, mismatched = 0;

  resv_monitor u_resv_monitor (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ll(input logic [31:0] a, input logic [1:0] p, input bit ex, input logic [31:0] d);
    @(negedge clk); req_valid = 1; req_op = 0; req_addr = a; req_prio = p;
    @(negedge clk); req_valid = 0;
    chk("R1 ll fetch_valid", fetch_valid, 1);
    chk("R1 ll fetch_addr", fetch_addr, a & ~32'd63);
    chk("R12 ready low", req_ready, 0);
    fill_valid = 1; fill_excl = ex; fill_data = d;
    @(negedge clk); fill_valid = 0;
    chk("R1 fetch one cycle", fetch_valid, 0);
    chk("R2 ll resp_valid", resp_valid, 1);
    chk("R2 ll resp_ok", resp_ok, 1);
    chk("R2 ll resp_data", resp_data, d);
    chk("R9 strict high", order_strict, 1);
  endtask

  task automatic sc(input logic [31:0] a, input logic [31:0] d, input bit exp_ok, input string tag);
    @(negedge clk); req_valid = 1; req_op = 1; req_addr = a; req_data = d;
    @(negedge clk); req_valid = 0;
    chk({tag, " sc resp_valid"}, resp_valid, 1);
    chk({tag, " sc resp_ok"}, resp_ok, exp_ok);
    chk({tag, " sc wr_valid"}, wr_valid, exp_ok);
    if (exp_ok) begin
      chk({tag, " sc wr_addr"}, wr_addr, a);
      chk({tag, " sc wr_data"}, wr_data, d);
    end
    chk("R9 strict low after sc", order_strict, 0);
  endtask

  task automatic snoop(input logic [31:0] a, input logic [1:0] p, input bit eg, input bit eh, input string tag);
    @(negedge clk); snp_valid = 1; snp_addr = a; snp_prio = p;
    #1;
    chk({tag, " grant"}, snp_grant, eg);
    chk({"R11 ", tag, " hint"}, snp_hint, eh);
    @(negedge clk); snp_valid = 0;
  endtask

  task automatic cas(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                     input bit ex, input logic [31:0] fd);
    bit ok;
    ok = ex && (fd == c);
    @(negedge clk); req_valid = 1; req_op = 2; req_addr = a; req_cmp = c; req_data = s;
    @(negedge clk); req_valid = 0;
    chk("R1 cas fetch_valid", fetch_valid, 1);
    chk("R1 cas fetch_addr", fetch_addr, a & ~32'd63);
    fill_valid = 1; fill_excl = ex; fill_data = fd;
    @(negedge clk); fill_valid = 0;
    chk("R4/R5 cas resp_valid", resp_valid, 1);
    chk(ex ? "R5 cas resp_ok" : "R4 cas resp_ok", resp_ok, ok);
    chk(ex ? "R5 cas wr_valid" : "R4 cas wr_valid", wr_valid, ok);
    chk("R5 cas resp_data", resp_data, fd);
    if (ok) begin
      chk("R5 cas wr_addr", wr_addr, a);
      chk("R5 cas wr_data", wr_data, s);
    end
  endtask

  initial begin
    #(200000 * 8);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset strict", order_strict, 0);
    chk("R12 reset ready", req_ready, 1);
    chk("R1 reset fetch", fetch_valid, 0);
    chk("reset resp_valid", resp_valid, 0);
    snoop(32'h100, 0, 1, 0, "R8 no-resv");
    sc(32'h100, 32'h5, 0, "R10 no-resv");

    // R6/R7/R8/R11 sweep: holder priority x snooper priority x offset
    for (int hp = 0; hp < 4; hp++)
      for (int sp = 0; sp < 4; sp++)
        for (int k = 0; k < 4; k++) begin
          int off;
          bit hit, win;
          off = (k == 0) ? 0 : (k == 1) ? 17 : (k == 2) ? 63 : 64;
          base = 32'h4000 + 32'(hp * 4 + sp) * 32'h80;
          hit = off < 64;
          win = hit && (sp > hp);
          ll(base + 32'd8, 2'(hp), 1, 32'hA000 + 32'(hp));
          snoop(base + 32'(off), 2'(sp), !hit || win, hit,
                win ? "R6" : hit ? "R7" : "R8");
          chk("R9 strict kept after snoop", order_strict, 1);
          sc(base + 32'd4, 32'hD0 + 32'(k), !win, win ? "R6" : hit ? "R7" : "R8");
        end

    // R3: load-linked without exclusivity fails silently
    ll(32'h8000, 1, 0, 32'h77);
    sc(32'h8000, 32'h1, 0, "R3");
    ll(32'h8040, 1, 1, 32'h78);
    sc(32'h8044, 32'h2, 1, "R3 excl");

    // R10: wrong line, then double store-conditional
    ll(32'h9000, 2, 1, 32'h1);
    sc(32'h9040, 32'h3, 0, "R10 other-line");
    ll(32'h9000, 2, 1, 32'h1);
    sc(32'h903C, 32'h4, 1, "R10 first");
    sc(32'h903C, 32'h4, 0, "R10 second");

    // R4/R5 sweep over exclusivity and match
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 2; m++)
        cas(32'hA010 + 32'(e * 64 + m * 4), 32'h1234, 32'h99 + 32'(m),
            e[0], m[0] ? 32'h1234 : 32'h4321);

    // R12: request while fetch outstanding is ignored
    @(negedge clk); req_valid = 1; req_op = 0; req_addr = 32'hB000; req_prio = 0;
    @(negedge clk); req_op = 1; req_addr = 32'hB000;
    chk("R12 ready low during fetch", req_ready, 0);
    fill_valid = 1; fill_excl = 1; fill_data = 32'h5;
    @(negedge clk); req_valid = 0; fill_valid = 0;
    chk("R12 ll still answered", resp_ok, 1);
    chk("R12 reservation intact", order_strict, 1);
    sc(32'hB000, 32'h6, 1, "R12");

    // R11: hint high on tie deny, low on other line
    ll(32'hC000, 3, 1, 32'h0);
    snoop(32'hC03F, 3, 0, 1, "R7 tie");
    snoop(32'hC040, 3, 1, 0, "R8 other");
    sc(32'hC000, 32'h7, 1, "R7 tie");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule